// File: doc/BRIEF.md
# Accumulator Register-Operation Unit

This unit carries out the register-reference operations of a small accumulator machine. It acts on a 16-bit accumulator (AC) and a one-bit extension flag E, which holds the accumulator's carry-out. The controller pulses `start` with a 12-bit operation field and the present AC and E. One clock later the unit presents the new AC and E, a one-cycle request for the program counter to advance one extra time (a skip), and a halt flag.

The field is one-hot: each operation owns one bit. The rotations treat E and AC as one 17-bit ring. A field with no bit set, or with more than one bit set, changes nothing.

Top module: `acc_regop_unit`

## Requirements
- R1: While reset is asserted and after it is released, `ac_out`, `e_out`, `skip` and `halt` are all 0.
- R2: Results appear in the clock cycle after a `start` pulse. `ac_out` and `e_out` hold between pulses. `skip` is high for exactly that one cycle.
- R3: Field bit 11 (0x800) clears AC and keeps E. Field bit 10 (0x400) clears E and keeps AC.
- R4: Field bit 9 (0x200) inverts every AC bit and keeps E. Field bit 8 (0x100) inverts E and keeps AC.
- R5: Field bit 7 (0x080) rotates {E, AC} right by one place: AC[0] goes to E and the old E goes to AC[15].
- R6: Field bit 6 (0x040) rotates {E, AC} left by one place: AC[15] goes to E and the old E goes to AC[0].
- R7: Field bit 5 (0x020) adds one to AC modulo 2^16 and leaves E unchanged, also when AC wraps from 0xFFFF.
- R8: Field bit 4 (0x010) requests a skip when AC[15] is 0. Field bit 3 (0x008) requests a skip when AC[15] is 1. Both pass AC and E through unchanged.
- R9: Field bit 2 (0x004) requests a skip when AC equals 0. Field bit 1 (0x002) requests a skip when E is 0. Both pass AC and E through unchanged.
- R10: Field bit 0 (0x001) sets `halt`, which stays set until reset; AC and E pass through unchanged.
- R11: A field with zero bits set or with two or more bits set passes AC and E through, raises no skip and leaves `halt` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that executes the operation |
| op_field | input | 12 | One-hot operation field |
| ac_in | input | 16 | Present accumulator value |
| e_in | input | 1 | Present extension (carry) flag |
| ac_out | output | 16 | Updated accumulator |
| e_out | output | 1 | Updated extension flag |
| skip | output | 1 | One-cycle request for an extra program-counter increment |
| halt | output | 1 | Sticky halt flag |

## Verification
The hardest cases to reach are those where the value crossing between E and the accumulator decides the result. These are the rotations with E and the moving end bit set to opposite values, and an increment that wraps while E must stay put. The vector table drives each rotation twice, with E and the edge bit set to opposite values in both, so that a rotation that drops the ring bit or turns the wrong way gives a different word. Fields with several bits set are driven directly, to show that no single operation slips through. Directed steps check that the skip pulse lasts one cycle and that halt outlives later operations.

// File: rtl/acc_regop_pkg.sv
package acc_regop_pkg;

   localparam int REGOP_FIELD_W = 12;

   // One flag per field bit, most significant first (bit 11 .. bit 0).
   typedef struct packed {
      logic clr_ac;    // bit 11
      logic clr_e;     // bit 10
      logic cmp_ac;    // bit 9
      logic cmp_e;     // bit 8
      logic rot_r;     // bit 7
      logic rot_l;     // bit 6
      logic inc_ac;    // bit 5
      logic skp_pos;   // bit 4
      logic skp_neg;   // bit 3
      logic skp_zero;  // bit 2
      logic skp_ez;    // bit 1
      logic stop;      // bit 0
   } regop_sel_t;

endpackage

// File: rtl/regop_decode.sv
module regop_decode
   import acc_regop_pkg::*;
#(
   parameter int FIELD_W       = REGOP_FIELD_W,
   parameter bit STRICT_ONEHOT = 1'b1
) (
   input  logic [FIELD_W-1:0] field,
   output regop_sel_t         sel,
   output logic               legal
);

   generate
      if (FIELD_W != $bits(regop_sel_t)) begin : g_bad_width
         $error("regop_decode: FIELD_W must equal the selector width");
      end

      if (STRICT_ONEHOT) begin : g_strict
         always_comb begin
            legal = $onehot(field);
            sel   = legal ? regop_sel_t'(field) : '0;
         end
      end else begin : g_priority
         logic [FIELD_W-1:0] pick;
         always_comb begin
            pick = '0;
            for (int i = 0; i < FIELD_W; i++) begin
               if (field[i]) pick = FIELD_W'(1) << i;
            end
            legal = |field;
            sel   = regop_sel_t'(pick);
         end
      end
   endgenerate

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import acc_regop_pkg::*;
#(
   parameter int AC_W = 16
) (
   input  regop_sel_t      sel,
   input  logic [AC_W-1:0] ac,
   input  logic            e,
   output logic [AC_W-1:0] ac_nxt,
   output logic            e_nxt
);

   localparam int RING_W = AC_W + 1;

   generate
      if (AC_W < 2) begin : g_bad_width
         $error("acc_datapath: AC_W must be at least 2");
      end
   endgenerate

   logic [RING_W-1:0] ring;
   logic [RING_W-1:0] ring_r;
   logic [RING_W-1:0] ring_l;

   always_comb begin
      ring   = {e, ac};
      ring_r = {ring[0], ring[RING_W-1:1]};
      ring_l = {ring[RING_W-2:0], ring[RING_W-1]};
   end

   always_comb begin
      ac_nxt = ac;
      e_nxt  = e;
      if (sel.clr_ac) begin
         ac_nxt = '0;
      end else if (sel.clr_e) begin
         e_nxt = 1'b0;
      end else if (sel.cmp_ac) begin
         ac_nxt = ~ac;
      end else if (sel.cmp_e) begin
         e_nxt = ~e;
      end else if (sel.rot_r) begin
         {e_nxt, ac_nxt} = ring_r;
      end else if (sel.rot_l) begin
         {e_nxt, ac_nxt} = ring_l;
      end else if (sel.inc_ac) begin
         ac_nxt = ac + AC_W'(1);
      end
   end

endmodule

// File: rtl/skip_eval.sv
module skip_eval
   import acc_regop_pkg::*;
#(
   parameter int AC_W = 16
) (
   input  regop_sel_t      sel,
   input  logic [AC_W-1:0] ac,
   input  logic            e,
   output logic            skip_req
);

   localparam int SIGN_BIT = AC_W - 1;

   logic [3:0] hits;

   always_comb begin
      hits[0]  = sel.skp_pos  & ~ac[SIGN_BIT];
      hits[1]  = sel.skp_neg  &  ac[SIGN_BIT];
      hits[2]  = sel.skp_zero & (ac == '0);
      hits[3]  = sel.skp_ez   & ~e;
      skip_req = |hits;
   end

endmodule

// File: rtl/acc_regop_unit.sv
module acc_regop_unit
   import acc_regop_pkg::*;
#(
   parameter int AC_W          = 16,
   parameter int FIELD_W       = REGOP_FIELD_W,
   parameter bit STRICT_ONEHOT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FIELD_W-1:0] op_field,
   input  logic [AC_W-1:0]    ac_in,
   input  logic               e_in,
   output logic [AC_W-1:0]    ac_out,
   output logic               e_out,
   output logic               skip,
   output logic               halt
);

   localparam int MSB = AC_W - 1;

   regop_sel_t      sel;
   logic            legal;
   logic [AC_W-1:0] ac_nxt;
   logic            e_nxt;
   logic            skip_nxt;

   regop_decode #(
      .FIELD_W       (FIELD_W),
      .STRICT_ONEHOT (STRICT_ONEHOT)
   ) i_decode (
      .field (op_field),
      .sel   (sel),
      .legal (legal)
   );

   acc_datapath #(.AC_W(AC_W)) i_datapath (
      .sel    (sel),
      .ac     (ac_in),
      .e      (e_in),
      .ac_nxt (ac_nxt),
      .e_nxt  (e_nxt)
   );

   skip_eval #(.AC_W(AC_W)) i_skip (
      .sel      (sel),
      .ac       (ac_in),
      .e        (e_in),
      .skip_req (skip_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_out <= '0;
         e_out  <= 1'b0;
         skip   <= 1'b0;
         halt   <= 1'b0;
      end else begin
         skip <= start & skip_nxt;
         if (start) begin
            ac_out <= ac_nxt;
            e_out  <= e_nxt;
            if (legal && sel.stop) halt <= 1'b1;
         end
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (ac_out == $past(ac_out)) && (e_out == $past(e_out)) && !skip); // R2

   AST_CLEAR_AC: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_field == FIELD_W'(12'h800)) |=> (ac_out == '0) && (e_out == $past(e_in))); // R3

   AST_ROT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_field == FIELD_W'(12'h080))
      |=> (e_out == $past(ac_in[0])) && (ac_out[MSB] == $past(e_in))); // R5

   AST_ROT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_field == FIELD_W'(12'h040))
      |=> (e_out == $past(ac_in[MSB])) && (ac_out[0] == $past(e_in))); // R6

   AST_INC_KEEPS_E: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_field == FIELD_W'(12'h020)) |=> (e_out == $past(e_in))); // R7

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt); // R10

   AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && $countones(op_field) != 1)
      |=> (ac_out == $past(ac_in)) && (e_out == $past(e_in)) && !skip
          && (halt == $past(halt))); // R11

endmodule

// File: tb/test_acc_regop_unit.sv
module test_acc_regop_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] op_field = '0;
   logic [15:0] ac_in = '0;
   logic        e_in = 1'b0;
   logic [15:0] ac_out;
   logic        e_out;
   logic        skip;
   logic        halt;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;   // 50 MHz

   acc_regop_unit i_acc_regop_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op_field (op_field),
      .ac_in    (ac_in),
      .e_in     (e_in),
      .ac_out   (ac_out),
      .e_out    (e_out),
      .skip     (skip),
      .halt     (halt)
   );

   // {req, field, ac, e, exp_ac, exp_e, exp_skip}
   localparam int NV = 20;
   localparam logic [50:0] VEC [NV] = '{
      {4'd3,  12'h800, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0}, // R3 clear AC
      {4'd3,  12'h400, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0}, // R3 clear E
      {4'd4,  12'h200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 1'b0}, // R4 invert AC
      {4'd4,  12'h100, 16'h5555, 1'b0, 16'h5555, 1'b1, 1'b0}, // R4 invert E
      {4'd5,  12'h080, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0}, // R5
      {4'd5,  12'h080, 16'h8002, 1'b1, 16'hC001, 1'b0, 1'b0}, // R5
      {4'd6,  12'h040, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b0}, // R6
      {4'd6,  12'h040, 16'h4001, 1'b1, 16'h8003, 1'b0, 1'b0}, // R6
      {4'd7,  12'h020, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0}, // R7 wrap
      {4'd7,  12'h020, 16'h00FE, 1'b1, 16'h00FF, 1'b1, 1'b0}, // R7
      {4'd8,  12'h010, 16'h7FFF, 1'b0, 16'h7FFF, 1'b0, 1'b1}, // R8
      {4'd8,  12'h010, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b0}, // R8
      {4'd8,  12'h008, 16'h8000, 1'b1, 16'h8000, 1'b1, 1'b1}, // R8
      {4'd8,  12'h008, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0}, // R8
      {4'd9,  12'h004, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1}, // R9
      {4'd9,  12'h004, 16'h0001, 1'b0, 16'h0001, 1'b0, 1'b0}, // R9
      {4'd9,  12'h002, 16'h1111, 1'b0, 16'h1111, 1'b0, 1'b1}, // R9
      {4'd9,  12'h002, 16'h1111, 1'b1, 16'h1111, 1'b1, 1'b0}, // R9
      {4'd11, 12'h000, 16'hABCD, 1'b1, 16'hABCD, 1'b1, 1'b0}, // R11 empty
      {4'd11, 12'h880, 16'hABCD, 1'b0, 16'hABCD, 1'b0, 1'b0}  // R11 two bits
   };

   task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // Drive one start pulse, return at the negedge after the capturing edge.
   task automatic run_op(input logic [11:0] f, input logic [15:0] a, input logic e);
      @(negedge clk);
      start = 1'b1; op_field = f; ac_in = a; e_in = e;
      @(negedge clk);
      start = 1'b0; op_field = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs low during reset
      check("R1", {ac_out, e_out, skip}, 18'h0);
      check("R1", {17'h0, halt}, 18'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {ac_out, e_out, skip}, 18'h0);

      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][46:35], VEC[i][34:19], VEC[i][18]);
         check($sformatf("R%0d vec%0d", VEC[i][50:47], i),
               {ac_out, e_out, skip}, VEC[i][17:0]);
         check($sformatf("R11 halt vec%0d", i), {17'h0, halt}, 18'h0);
      end

      // R2: skip lasts one cycle, outputs hold while idle
      run_op(12'h004, 16'h0000, 1'b1);
      check("R2", {ac_out, e_out, skip}, {16'h0000, 1'b1, 1'b1});
      ac_in = 16'h7777; e_in = 1'b0;
      @(negedge clk);
      check("R2", {ac_out, e_out, skip}, {16'h0000, 1'b1, 1'b0});
      @(negedge clk);
      check("R2", {ac_out, e_out, skip}, {16'h0000, 1'b1, 1'b0});

      // R2: result appears only after the capturing edge
      @(negedge clk);
      start = 1'b1; op_field = 12'h200; ac_in = 16'h0F0F; e_in = 1'b0;
      #1;
      check("R2 before edge", {ac_out, e_out, skip}, {16'h0000, 1'b1, 1'b0});
      @(negedge clk);
      start = 1'b0;
      check("R2 after edge", {ac_out, e_out, skip}, {16'hF0F0, 1'b0, 1'b0});

      // R10: halt sets, passes data, and sticks
      run_op(12'h001, 16'h2468, 1'b1);
      check("R10", {ac_out, e_out, skip}, {16'h2468, 1'b1, 1'b0});
      check("R10", {17'h0, halt}, 18'h1);
      run_op(12'h020, 16'h0001, 1'b0);
      check("R10 sticky", {17'h0, halt}, 18'h1);
      check("R7 after halt", {ac_out, e_out, skip}, {16'h0002, 1'b0, 1'b0});

      // R11: halt bit combined with another bit does not halt (checked after reset)
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset", {17'h0, halt}, 18'h0);
      rst_n = 1'b1;
      run_op(12'h011, 16'h0005, 1'b1);
      check("R11", {ac_out, e_out, skip}, {16'h0005, 1'b1, 1'b0});
      check("R11", {17'h0, halt}, 18'h0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule